// File: doc/BRIEF.md
# Reconfigurable Region Identity Monitor

This block checks which hardware task actually occupies each reconfigurable region of a shared fabric and whether each software client is who it claims to be. Each check round releases one fresh 64-bit challenge to all regions and all clients. Every region and every client then returns one keyed-hash response over its own valid/ready handshake. The monitor holds a table of expected responses. Task entries come first, with entry 0 reserved for the dummy task that fills unused regions, and one entry per client follows them. The monitor also holds an allocation record per region, written by the reconfiguration manager, that names the task meant to sit in that region.

A region response that matches no task entry marks the region as hidden, because some unregistered logic is loaded there. A response that matches a registered task other than the allocated one marks the region as redirected. Any failing region is latched as the attack location. Software computes the expected responses from the challenge shown on `chal` and loads them while the monitor is idle, then starts a round. A client is granted activation only when its own response and the response of its assigned region both check out. Rounds are meant to be started again and again while the system runs.

Top module: `region_integrity_monitor`

## Requirements
- R1: `chal` shows the state of a 64-bit Fibonacci LFSR. The new bit 0 is bit63^bit62^bit60^bit59, and the rest of the state shifts one place toward the MSB. The state starts at parameter SEED. It stays stable, with `chal_vld` and `busy` high, throughout a round, and it advances exactly one step when a round completes.
- R2: A start while idle is refused when the round counter (CTRW bits, incremented on each accepted start) is all ones, or when any two table entries are equal. A refusal gives a one-cycle `start_rej` pulse on the cycle after the start and does not begin a round.
- R3: During a round, `src_ready[i]` is high exactly for the sources whose response has not yet been taken. Source i is region i for i < NREG and client i-NREG otherwise. Each source is taken once, on a cycle with valid and ready both high.
- R4: A region whose response equals the table entry of its allocated task gets status 2'b00. Allocations reset to task 0, the dummy entry, so an unallocated region passes with the dummy response.
- R5: A region whose response matches no task entry (0..NTASK-1) gets status 2'b01 and sets `alert_hide`.
- R6: A region whose response matches a task entry other than its allocated one gets status 2'b10 and sets `alert_redir`.
- R7: A source not taken within `timeout_cyc` cycles gets status 2'b11 and sets `alert_hide`. The round then ends, with `done` visible `timeout_cyc`+1 cycles after the cycle in which `busy` first shows high.
- R8: Client c passes (2'b00) when its response equals table entry NTASK+c, and otherwise gets 2'b01.
- R9: `grant[c]` drops when a round starts and rises at the end of the round only if client c and the region given by its field of `cli_map` both have status 2'b00.
- R10: `alert_hide`, `alert_redir` and the location (`loc_vld`, `loc_idx`) stay set until `alert_clr`. The location latches the lowest-index failing region of the first failing round and ignores client-only failures.
- R11: Table and allocation writes are ignored while a round is running.
- R12: A round ends with a one-cycle `done` pulse once every source is taken or the timeout is reached. Source i's status sits at `status[2i+1:2i]` and holds until the next round starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Expected-response table write strobe |
| tbl_idx | input | EIW | Table entry: tasks first, then clients |
| tbl_data | input | W | Expected response to store |
| alloc_we | input | 1 | Allocation record write strobe |
| alloc_rr | input | RIW | Region of the allocation record |
| alloc_tid | input | TIW | Task allocated to that region |
| cli_map | input | NCLI*RIW | Region assigned to each client |
| timeout_cyc | input | TOW | Response timeout in cycles |
| start | input | 1 | Request a check round |
| chal | output | 64 | Current challenge |
| chal_vld | output | 1 | Challenge released |
| busy | output | 1 | Round in progress |
| start_rej | output | 1 | Start refused pulse |
| src_valid | input | NSRC | Response valid per source |
| src_resp | input | NSRC*W | Responses, source i at bits [i*W +: W] |
| src_ready | output | NSRC | Response ready per source |
| done | output | 1 | Round complete pulse |
| status | output | 2*NSRC | Per-source status |
| alert_hide | output | 1 | Sticky task-hiding alert |
| alert_redir | output | 1 | Sticky redirection alert |
| loc_vld | output | 1 | Attack location latched |
| loc_idx | output | RIW | Index of the failing region |
| grant | output | NCLI | Activation permitted per client |
| alert_clr | input | 1 | Clear alerts and location |

## Verification
Almost every internal fault surfaces at the end of the round in which it occurs. A wrong comparison or a stale allocation shows up in `status` on the `done` cycle, and the sticky alerts and location latch follow on the same edge. A broken capture flag or timer shows up as early or late `done`, or as a `src_ready` pattern that does not match the sources still owed, one cycle after the capture. Faults in the LFSR or the round counter show only across rounds: as a wrong `chal` right after a `done`, or as a refusal that appears too early or never comes.

// File: rtl/region_integrity_monitor.sv
module region_integrity_monitor #(
  parameter int          NREG  = 3,
  parameter int          NCLI  = 2,
  parameter int          NTASK = 4,
  parameter int          W     = 64,
  parameter int          CTRW  = 64,
  parameter int          TOW   = 16,
  parameter logic [63:0] SEED  = 64'h0123_4567_89AB_CDEF,
  localparam int NSRC = NREG + NCLI,
  localparam int NENT = NTASK + NCLI,
  localparam int RIW  = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int TIW  = (NTASK > 1) ? $clog2(NTASK) : 1,
  localparam int EIW  = $clog2(NENT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tbl_we,
  input  logic [EIW-1:0]      tbl_idx,
  input  logic [W-1:0]        tbl_data,
  input  logic                alloc_we,
  input  logic [RIW-1:0]      alloc_rr,
  input  logic [TIW-1:0]      alloc_tid,
  input  logic [NCLI*RIW-1:0] cli_map,
  input  logic [TOW-1:0]      timeout_cyc,
  input  logic                start,
  output logic [63:0]         chal,
  output logic                chal_vld,
  output logic                busy,
  output logic                start_rej,
  input  logic [NSRC-1:0]     src_valid,
  input  logic [NSRC*W-1:0]   src_resp,
  output logic [NSRC-1:0]     src_ready,
  output logic                done,
  output logic [2*NSRC-1:0]   status,
  output logic                alert_hide,
  output logic                alert_redir,
  output logic                loc_vld,
  output logic [RIW-1:0]      loc_idx,
  output logic [NCLI-1:0]     grant,
  input  logic                alert_clr
);

  logic [W-1:0]     tbl   [NENT];
  logic [TIW-1:0]   alloc [NREG];
  logic [63:0]      lfsr;
  logic [CTRW-1:0]  ctr;
  logic             in_col;
  logic [TOW-1:0]   tmr;
  logic [NSRC-1:0]  got;
  logic [1:0]       st    [NSRC];

  logic [NSRC-1:0]  take, got_nx;
  logic [1:0]       ev    [NSRC];
  logic [1:0]       st_nx [NSRC];
  logic [NTASK-1:0] hit   [NREG];
  logic             collide, fin, hide_f, redir_f, bad_any;
  logic [RIW-1:0]   loc_nx;
  logic [NCLI-1:0]  grant_nx;

  assign chal      = lfsr;
  assign chal_vld  = in_col;
  assign busy      = in_col;
  assign src_ready = in_col ? ~got : '0;
  assign take      = src_valid & src_ready;
  assign got_nx    = got | take;
  assign fin       = in_col && ((&got_nx) || (tmr == timeout_cyc));

  for (genvar i = 0; i < NSRC; i++) begin : g_stat
    assign status[2*i +: 2] = st[i];
  end

  always_comb begin
    collide = 1'b0;
    for (int i = 0; i < NENT; i++)
      for (int j = i + 1; j < NENT; j++)
        if (tbl[i] == tbl[j]) collide = 1'b1;
  end

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      for (int j = 0; j < NTASK; j++)
        hit[r][j] = (src_resp[r*W +: W] == tbl[j]);
      if (hit[r] == '0)          ev[r] = 2'b01;
      else if (hit[r][alloc[r]]) ev[r] = 2'b00;
      else                       ev[r] = 2'b10;
    end
    for (int c = 0; c < NCLI; c++)
      ev[NREG+c] = (src_resp[(NREG+c)*W +: W] == tbl[NTASK+c]) ? 2'b00 : 2'b01;
  end

  always_comb begin
    hide_f  = 1'b0;
    redir_f = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      st_nx[i] = take[i] ? ev[i] : st[i];
      if (st_nx[i] == 2'b01 || st_nx[i] == 2'b11) hide_f  = 1'b1;
      if (st_nx[i] == 2'b10)                      redir_f = 1'b1;
    end
    loc_nx  = '0;
    bad_any = 1'b0;
    for (int r = NREG - 1; r >= 0; r--)
      if (st_nx[r] != 2'b00) begin
        loc_nx  = RIW'(r);
        bad_any = 1'b1;
      end
    for (int c = 0; c < NCLI; c++)
      grant_nx[c] = (st_nx[NREG+c] == 2'b00) &&
                    (int'(cli_map[c*RIW +: RIW]) < NREG) &&
                    (st_nx[cli_map[c*RIW +: RIW]] == 2'b00);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) tbl[i]   <= '0;
      for (int r = 0; r < NREG; r++) alloc[r] <= '0;
      for (int i = 0; i < NSRC; i++) st[i]    <= 2'b00;
      lfsr        <= SEED;
      ctr         <= '0;
      in_col      <= 1'b0;
      tmr         <= '0;
      got         <= '0;
      start_rej   <= 1'b0;
      done        <= 1'b0;
      alert_hide  <= 1'b0;
      alert_redir <= 1'b0;
      loc_vld     <= 1'b0;
      loc_idx     <= '0;
      grant       <= '0;
    end else begin
      start_rej <= 1'b0;
      done      <= 1'b0;
      if (alert_clr) begin
        alert_hide  <= 1'b0;
        alert_redir <= 1'b0;
        loc_vld     <= 1'b0;
      end
      if (!in_col) begin
        if (tbl_we && int'(tbl_idx) < NENT) tbl[tbl_idx] <= tbl_data;
        if (alloc_we && int'(alloc_rr) < NREG) alloc[alloc_rr] <= alloc_tid;
        if (start) begin
          if (collide || (&ctr)) start_rej <= 1'b1;
          else begin
            in_col <= 1'b1;
            ctr    <= ctr + 1'b1;
            got    <= '0;
            tmr    <= '0;
            grant  <= '0;
            for (int i = 0; i < NSRC; i++) st[i] <= 2'b11;
          end
        end
      end else begin
        got <= got_nx;
        tmr <= tmr + 1'b1;
        for (int i = 0; i < NSRC; i++) st[i] <= st_nx[i];
        if (fin) begin
          in_col <= 1'b0;
          done   <= 1'b1;
          lfsr   <= {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
          grant  <= grant_nx;
          if (hide_f)  alert_hide  <= 1'b1;
          if (redir_f) alert_redir <= 1'b1;
          if (bad_any && !loc_vld) begin
            loc_vld <= 1'b1;
            loc_idx <= loc_nx;
          end
        end
      end
    end
  end

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_reject_no_round: assert property (@(posedge clk) disable iff (!rst_n)
    start_rej |-> !busy);
  a_r1_chal_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (chal_vld && $past(chal_vld)) |-> $stable(chal));
  a_r1_chal_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    chal != 64'd0);
  a_r10_hide_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_hide && !alert_clr) |=> alert_hide);
  a_r10_redir_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (alert_redir && !alert_clr) |=> alert_redir);
  a_r10_loc_has_alert: assert property (@(posedge clk) disable iff (!rst_n)
    loc_vld |-> (alert_hide || alert_redir));
  for (genvar c = 0; c < NCLI; c++) begin : g_grant_chk
    a_r9_grant_rise_ok: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant[c]) |-> (done && status[2*(NREG+c) +: 2] == 2'b00));
  end

endmodule

// File: tb/region_integrity_monitor_tb.sv
module region_integrity_monitor_tb;
  localparam int NREG = 3, NCLI = 2, NTASK = 4, W = 64, NSRC = 5;
  localparam logic [63:0] SEED = 64'h0123_4567_89AB_CDEF;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic tbl_we = 0, alloc_we = 0, start = 0, alert_clr = 0;
  logic [2:0] tbl_idx = 0;
  logic [63:0] tbl_data = 0;
  logic [1:0] alloc_rr = 0, alloc_tid = 0;
  logic [3:0] cli_map = {2'd1, 2'd0};
  logic [15:0] timeout_cyc = 16'd20;
  logic [NSRC-1:0] src_valid = 0;
  logic [63:0] rsp [NSRC];
  logic [NSRC*W-1:0] src_resp;
  always_comb for (int i = 0; i < NSRC; i++) src_resp[i*W +: W] = rsp[i];

  logic [63:0] chal, w_chal;
  logic chal_vld, busy, start_rej, done, alert_hide, alert_redir, loc_vld;
  logic w_chal_vld, w_busy, w_start_rej, w_done, w_ah, w_ar, w_lv;
  logic [NSRC-1:0] src_ready, w_ready;
  logic [2*NSRC-1:0] status, w_status;
  logic [1:0] loc_idx, w_li, grant, w_grant;

  region_integrity_monitor #(.SEED(SEED)) u_dut (
    .clk, .rst_n, .tbl_we, .tbl_idx, .tbl_data, .alloc_we, .alloc_rr, .alloc_tid,
    .cli_map, .timeout_cyc, .start, .chal, .chal_vld, .busy, .start_rej,
    .src_valid, .src_resp, .src_ready, .done, .status, .alert_hide, .alert_redir,
    .loc_vld, .loc_idx, .grant, .alert_clr);

  region_integrity_monitor #(.SEED(SEED), .CTRW(2)) u_wrap (
    .clk, .rst_n, .tbl_we, .tbl_idx, .tbl_data, .alloc_we, .alloc_rr, .alloc_tid,
    .cli_map, .timeout_cyc, .start, .chal(w_chal), .chal_vld(w_chal_vld), .busy(w_busy),
    .start_rej(w_start_rej), .src_valid, .src_resp, .src_ready(w_ready), .done(w_done),
    .status(w_status), .alert_hide(w_ah), .alert_redir(w_ar), .loc_vld(w_lv),
    .loc_idx(w_li), .grant(w_grant), .alert_clr);

  int n_run = 0, n_fail = 0;
  logic rej_m, rej_w, busy_seen, vld_seen;
  logic [63:0] chal_seen;
  int wait_cyc;

  function automatic logic [63:0] tv(input int j);
    return 64'hA5A5_0000_0000_0000 + 64'(j) * 64'h1111_2222;
  endfunction
  function automatic logic [63:0] cv(input int c);
    return 64'hC3C3_0000_0000_0000 + 64'(c) * 64'h0F0F;
  endfunction
  function automatic logic [63:0] step(input logic [63:0] s);
    return {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_tbl(input int idx, input logic [63:0] d);
    @(negedge clk); tbl_we = 1; tbl_idx = 3'(idx); tbl_data = d;
    @(negedge clk); tbl_we = 0;
  endtask
  task automatic wr_alloc(input int r, input int t);
    @(negedge clk); alloc_we = 1; alloc_rr = 2'(r); alloc_tid = 2'(t);
    @(negedge clk); alloc_we = 0;
  endtask
  task automatic clear_alerts();
    @(negedge clk); alert_clr = 1;
    @(negedge clk); alert_clr = 0;
  endtask
  task automatic good_resp();
    rsp[0] = tv(1); rsp[1] = tv(2); rsp[2] = tv(0); rsp[3] = cv(0); rsp[4] = cv(1);
  endtask

  // mid: at the first cycle after capture, check ready and write while busy (R3, R11)
  task automatic run_round(input logic [NSRC-1:0] vmask, input bit mid);
    @(negedge clk); src_valid = vmask; start = 1;
    @(negedge clk); start = 0;
    rej_m = start_rej; rej_w = w_start_rej; busy_seen = busy;
    vld_seen = chal_vld; chal_seen = chal; wait_cyc = 0;
    if (busy) begin
      while (!done && wait_cyc < 40) begin
        @(negedge clk); wait_cyc++;
        if (mid && wait_cyc == 1) begin
          check("R3 ready only for sources still owed", 64'(src_ready), 64'h10);
          tbl_we = 1; tbl_idx = 3'd1; tbl_data = 64'hBAD0;
          alloc_we = 1; alloc_rr = 2'd2; alloc_tid = 2'd3;
        end
        if (mid && wait_cyc == 2) begin tbl_we = 0; alloc_we = 0; end
      end
    end
    src_valid = 0; tbl_we = 0; alloc_we = 0;
  endtask

  task automatic t_reset();
    check("R12 reset status", 64'(status), 0);
    check("R10 reset alerts", {62'd0, alert_hide, alert_redir}, 0);
    check("R9 reset grant", 64'(grant), 0);
    check("R1 reset challenge is seed", chal, SEED);
    check("R12 reset idle", 64'(busy), 0);
  endtask

  task automatic t_all_ok();
    good_resp();
    run_round(5'b11111, 0);
    check("R1 challenge released during round", {63'd0, vld_seen}, 1);
    check("R1 challenge value in round", chal_seen, SEED);
    check("R4 all regions ok incl dummy", 64'(status), 0);
    check("R9 grants after clean round", 64'(grant), 2'b11);
    check("R12 done seen", 64'(done), 1);
    @(negedge clk);
    check("R12 done is one cycle", 64'(done), 0);
    check("R1 challenge advanced once", chal, step(SEED));
    check("R10 no alerts on clean round", {62'd0, alert_hide, alert_redir}, 0);
  endtask

  task automatic t_hidden();
    good_resp(); rsp[1] = 64'hDEAD_BEEF;
    run_round(5'b11111, 0);
    check("R1 second challenge", chal_seen, step(SEED));
    check("R5 region1 hidden", 64'(status), 10'h004);
    check("R5 hide alert", 64'(alert_hide), 1);
    check("R10 location region1", {61'd0, loc_vld, loc_idx}, {61'd0, 1'b1, 2'd1});
    check("R9 grant only client0", 64'(grant), 2'b01);
    clear_alerts();
    check("R10 cleared", {61'd0, alert_hide, alert_redir, loc_vld}, 0);
  endtask

  task automatic t_redirect();
    good_resp(); rsp[0] = tv(2);
    run_round(5'b11111, 0);
    check("R6 region0 redirected", 64'(status), 10'h002);
    check("R6 redir alert", {62'd0, alert_hide, alert_redir}, 2'b01);
    check("R10 location region0", {61'd0, loc_vld, loc_idx}, {61'd0, 1'b1, 2'd0});
    check("R9 grant only client1", 64'(grant), 2'b10);
  endtask

  task automatic t_timeout_wrap();
    good_resp(); timeout_cyc = 16'd6;
    run_round(5'b01111, 1);
    check("R2 counter at max refuses", {62'd0, rej_w, rej_m}, 2'b10);
    check("R7 timeout round length", 64'(wait_cyc), 7);
    check("R7 client1 timed out", 64'(status), 10'h300);
    check("R7 timeout raises hide", 64'(alert_hide), 1);
    check("R10 redir still held", 64'(alert_redir), 1);
    check("R10 location kept", {61'd0, loc_vld, loc_idx}, {61'd0, 1'b1, 2'd0});
    check("R9 grant drops for timed-out client", 64'(grant), 2'b01);
    timeout_cyc = 16'd20;
    clear_alerts();
  endtask

  task automatic t_collision();
    wr_tbl(3, tv(1));
    good_resp();
    run_round(5'b11111, 0);
    check("R2 collision refuses", {62'd0, rej_m, busy_seen}, 2'b10);
    wr_tbl(3, tv(3));
  endtask

  task automatic t_busy_write_ignored();
    good_resp();
    run_round(5'b11111, 0);
    check("R11 writes during busy ignored", 64'(status), 0);
    check("R11 grants intact", 64'(grant), 2'b11);
  endtask

  task automatic t_client_bad();
    good_resp(); rsp[3] = 64'h1234;
    run_round(5'b11111, 0);
    check("R8 client0 mismatch", 64'(status), 10'h040);
    check("R8 grant without client0", 64'(grant), 2'b10);
    check("R10 client failure no location", 64'(loc_vld), 0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    good_resp();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    for (int j = 0; j < NTASK; j++) wr_tbl(j, tv(j));
    for (int c = 0; c < NCLI; c++) wr_tbl(NTASK + c, cv(c));
    wr_alloc(0, 1);
    wr_alloc(1, 2);
    t_all_ok();
    t_hidden();
    t_redirect();
    t_timeout_wrap();
    t_collision();
    t_busy_write_ignored();
    t_client_bad();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule